// File: doc/BRIEF.md
# Single-Accumulator Four-Instruction Processor Core

This block is a very small 8-bit processor built around one accumulator. It reads its program and its operands from a 64-byte external memory through a 6-bit address output, a read strobe and an 8-bit data input. It never writes memory. Each instruction byte holds a 2-bit opcode in bits 7..6 and a 6-bit operand address in bits 5..0. The four instructions are add-from-memory, AND-from-memory, jump and increment-accumulator.

A state machine runs every instruction as a fixed sequence of register transfers. The three fetch states are FETCH1, FETCH2 and FETCH3, and the execute states are ADD1, ADD2, AND1, AND2, JMP1 and INC1. The transitions are:
- FETCH1 to FETCH2.
- FETCH2 to FETCH3.
- FETCH3 to ADD1, AND1, JMP1 or INC1, chosen by the opcode of the fetched byte.
- ADD1 to ADD2, and AND1 to AND2.
- ADD2, AND2, JMP1 and INC1 back to FETCH1.

Inside the core there are five registers: an address register, a program counter, a data register, an instruction register and the accumulator. Memory data and the program counter reach the registers over a shared internal bus. A two-function ALU forms either the sum or the bitwise AND of the accumulator and the data register. The accumulator value is brought out on a port so that the result of a program can be observed.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the address register, the data register, the instruction register and the accumulator, and sets the state to FETCH1. After reset, mem_addr is 0, mem_rd is 0 and acc_value is 0.
- R2: Fetch takes three cycles. In FETCH1 the address register takes the program counter. In FETCH2 mem_rd is high, the data register captures mem_rdata at mem_addr, and the program counter steps by one. In FETCH3 the instruction register takes bits 7..6 of the byte and the address register takes bits 5..0.
- R3: The opcode in bits 7..6 is decoded as 00 ADD, 01 AND, 10 JMP and 11 INC. FETCH3 moves to ADD1, AND1, JMP1 or INC1 according to that opcode.
- R4: ADD reads the byte at the operand address in ADD1, with mem_rd high and mem_addr equal to the operand. In ADD2 the accumulator becomes accumulator plus that byte, modulo 256. The whole instruction takes 5 cycles.
- R5: AND follows the same pattern: AND1 reads the operand, and in AND2 the accumulator becomes the bitwise AND of the accumulator and that byte. The whole instruction takes 5 cycles.
- R6: JMP loads the program counter with the operand bits 5..0 in JMP1, without a memory read. The next fetch reads from that address. The whole instruction takes 4 cycles.
- R7: INC adds one to the accumulator in INC1, so 0xFF wraps to 0x00. The whole instruction takes 4 cycles.
- R8: The program counter wraps from 63 to 0 when it steps.
- R9: mem_rd is high exactly in FETCH2, ADD1 and AND1. mem_addr always shows the address register and changes only after FETCH1 or FETCH3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 6 | Memory read address (address register) |
| mem_rd | output | 1 | Read strobe; mem_rdata must be valid while it is high |
| mem_rdata | input | 8 | Memory read data |
| acc_value | output | 8 | Current accumulator contents |

## Verification
Every output is a register or a decode of the state register, so each result shows one clock edge after the state that produces it:
- the new address appears the cycle after FETCH1 or FETCH3;
- the read strobe appears in the same cycle as the read state;
- an ADD or AND result appears in acc_value the cycle after ADD2 or AND2, which is 5 cycles after its FETCH1;
- an INC result appears 4 cycles after its FETCH1.

The bench advances a behavioural phase model once per rising edge and compares all three outputs at every falling edge, so each value is sampled in the cycle where it is due. It runs two programs, with a reset applied in the middle of an instruction. The programs cover opcode decoding, accumulator wrap on add and on increment, a jump to address 63 and the program counter wrapping to 0.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W = 2;

    typedef enum logic [3:0] {
        ST_FETCH1,
        ST_FETCH2,
        ST_FETCH3,
        ST_ADD1,
        ST_ADD2,
        ST_AND1,
        ST_AND2,
        ST_JMP1,
        ST_INC1
    } cpu_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_AND = 2'b01,
        OP_JMP = 2'b10,
        OP_INC = 2'b11
    } opcode_e;

    typedef struct packed {
        logic ar_from_bus;
        logic ar_from_dr;
        logic pc_step;
        logic pc_load;
        logic dr_load;
        logic ir_load;
        logic ac_load;
        logic ac_step;
        logic alu_and;
        logic bus_mem;
        logic bus_pc;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sel_and,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        if (sel_and) begin
            result = op_a & op_b;
        end else begin
            result = op_a + op_b;
        end
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] fetched_op,
    output cpu_state_e      state,
    output ctrl_t           ctl,
    output logic            mem_rd
);

    cpu_state_e state_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH1;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = ST_FETCH1;
        unique case (state)
            ST_FETCH1: state_n = ST_FETCH2;
            ST_FETCH2: state_n = ST_FETCH3;
            ST_FETCH3: begin
                unique case (opcode_e'(fetched_op))
                    OP_ADD: state_n = ST_ADD1;
                    OP_AND: state_n = ST_AND1;
                    OP_JMP: state_n = ST_JMP1;
                    OP_INC: state_n = ST_INC1;
                    default: state_n = ST_FETCH1;
                endcase
            end
            ST_ADD1:   state_n = ST_ADD2;
            ST_AND1:   state_n = ST_AND2;
            ST_ADD2, ST_AND2, ST_JMP1, ST_INC1: state_n = ST_FETCH1;
            default:   state_n = ST_FETCH1;
        endcase
    end

    always_comb begin
        ctl    = '0;
        mem_rd = 1'b0;
        unique case (state)
            ST_FETCH1: begin
                ctl.bus_pc      = 1'b1;
                ctl.ar_from_bus = 1'b1;
            end
            ST_FETCH2: begin
                ctl.bus_mem = 1'b1;
                ctl.dr_load = 1'b1;
                ctl.pc_step = 1'b1;
                mem_rd      = 1'b1;
            end
            ST_FETCH3: begin
                ctl.ir_load    = 1'b1;
                ctl.ar_from_dr = 1'b1;
            end
            ST_ADD1, ST_AND1: begin
                ctl.bus_mem = 1'b1;
                ctl.dr_load = 1'b1;
                mem_rd      = 1'b1;
            end
            ST_ADD2: ctl.ac_load = 1'b1;
            ST_AND2: begin
                ctl.ac_load = 1'b1;
                ctl.alu_and = 1'b1;
            end
            ST_JMP1: ctl.pc_load = 1'b1;
            ST_INC1: ctl.ac_step = 1'b1;
            default: ;
        endcase
    end

    // R3
    fetch3_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH3) |=> (state == ST_ADD1 || state == ST_AND1 ||
                                  state == ST_JMP1 || state == ST_INC1));

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] alu_result,
    output logic [ADDR_W-1:0] ar_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [DATA_W-1:0] dr_q,
    output logic [OP_W-1:0]   ir_q,
    output logic [DATA_W-1:0] ac_q
);

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] bus;

    always_comb begin
        bus = '0;
        if (ctl.bus_mem) begin
            bus = mem_rdata;
        end else if (ctl.bus_pc) begin
            bus = {{PAD_W{1'b0}}, pc_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
        end else if (ctl.ar_from_bus) begin
            ar_q <= bus[ADDR_W-1:0];
        end else if (ctl.ar_from_dr) begin
            ar_q <= dr_q[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (ctl.pc_load) begin
            pc_q <= dr_q[ADDR_W-1:0];
        end else if (ctl.pc_step) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_q <= '0;
        end else if (ctl.dr_load) begin
            dr_q <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (ctl.ir_load) begin
            ir_q <= dr_q[DATA_W-1 -: OP_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0;
        end else if (ctl.ac_load) begin
            ac_q <= alu_result;
        end else if (ctl.ac_step) begin
            ac_q <= ac_q + 1'b1;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - OP_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_value
);

    cpu_state_e        state;
    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] dr_q;
    logic [OP_W-1:0]   ir_q;
    logic [DATA_W-1:0] alu_result;

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fetched_op (dr_q[DATA_W-1 -: OP_W]),
        .state      (state),
        .ctl        (ctl),
        .mem_rd     (mem_rd)
    );

    acc_cpu_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .ar_q       (mem_addr),
        .pc_q       (pc_q),
        .dr_q       (dr_q),
        .ir_q       (ir_q),
        .ac_q       (acc_value)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_a    (acc_value),
        .op_b    (dr_q),
        .sel_and (ctl.alu_and),
        .result  (alu_result)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && acc_value == '0 && mem_addr == '0 && state == ST_FETCH1));

    // R2
    fetch_pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH2) |=> (pc_q == $past(pc_q) + 1'b1));

    // R3
    ir_add_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADD1 || state == ST_ADD2) |-> (ir_q == OP_ADD));

    // R3
    ir_and_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AND1 || state == ST_AND2) |-> (ir_q == OP_AND));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JMP1) |=> (pc_q == $past(mem_addr)));

    // R7
    acc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INC1) |=> (acc_value == $past(acc_value) + 1'b1));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH1 && state != ST_FETCH3) |=> $stable(mem_addr));

endmodule

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] mem_addr;
    logic       mem_rd;
    logic [7:0] mem_rdata;
    logic [7:0] acc_value;

    logic [7:0] mem [64];

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // behavioural reference state
    int ph, m_pc, m_ar, m_dr, m_ac, m_op;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    acc_cpu uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .acc_value (acc_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ph = 0; m_pc = 0; m_ar = 0; m_dr = 0; m_ac = 0; m_op = 0;
    endtask

    function automatic string tag_now();
        if (ph < 3) return (ph == 1 && m_pc == 63) ? "R8 pc wrap fetch" : "R2 fetch";
        case (m_op)
            0: return "R3/R4 add";
            1: return "R3/R5 and";
            2: return "R3/R6 jmp";
            default: return "R3/R7 inc";
        endcase
    endfunction

    task automatic compare_now();
        string t;
        int exp_rd;
        t = tag_now();
        exp_rd = (ph == 1 || (ph == 3 && m_op < 2)) ? 1 : 0;
        check({t, " addr"}, int'(mem_addr), m_ar);
        check({"R9 strobe ", t}, int'(mem_rd), exp_rd);
        check({t, " acc"}, int'(acc_value), m_ac);
    endtask

    task automatic model_step();
        case (ph)
            0: begin m_ar = m_pc; ph = 1; end
            1: begin m_dr = int'(mem[m_ar]); m_pc = (m_pc + 1) % 64; ph = 2; end
            2: begin m_op = m_dr / 64; m_ar = m_dr % 64; ph = 3; end
            3: begin
                if (m_op < 2) begin
                    m_dr = int'(mem[m_ar]); ph = 4;
                end else if (m_op == 2) begin
                    m_pc = m_dr % 64; ph = 0;
                end else begin
                    m_ac = (m_ac + 1) % 256; ph = 0;
                end
            end
            default: begin
                if (m_op == 0) m_ac = (m_ac + m_dr) % 256;
                else m_ac = m_ac & m_dr;
                ph = 0;
            end
        endcase
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            compare_now();
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic check_reset();
        check("R1 reset addr", int'(mem_addr), 0);
        check("R1 reset strobe", int'(mem_rd), 0);
        check("R1 reset acc", int'(acc_value), 0);
    endtask

    // opcodes: 00 ADD, 01 AND, 10 JMP, 11 INC in bits 7..6
    task automatic load_prog1();
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[0]  = 8'hC0;  // INC
        mem[1]  = 8'h20;  // ADD [32]
        mem[2]  = 8'h21;  // ADD [33] -> wraps
        mem[3]  = 8'h62;  // AND [34]
        mem[4]  = 8'hC0;  // INC
        mem[5]  = 8'hBE;  // JMP 62
        mem[62] = 8'hC0;  // INC
        mem[63] = 8'hC0;  // INC, then pc wraps to 0
        mem[32] = 8'h7F;
        mem[33] = 8'h90;
        mem[34] = 8'h30;
    endtask

    task automatic load_prog2();
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[0]  = 8'h30;  // ADD [48] -> 0xFF
        mem[1]  = 8'hC0;  // INC -> wraps to 0x00
        mem[2]  = 8'h31;  // ADD [49]
        mem[3]  = 8'h72;  // AND [50]
        mem[4]  = 8'hBF;  // JMP 63
        mem[63] = 8'hC0;  // INC, pc wraps to 0
        mem[48] = 8'hFF;
        mem[49] = 8'hA5;
        mem[50] = 8'h3C;
    endtask

    initial begin
        load_prog1();
        model_reset();
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        run_cycles(250);
        // reset in the middle of a program
        rst = 1'b1;
        load_prog2();
        model_reset();
        @(negedge clk);
        check_reset();
        @(negedge clk);
        check_reset();
        rst = 1'b0;
        run_cycles(250);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule